// File: doc/BRIEF.md
# Signature Register with Nibble Readout

The block compresses a serial stream of probe levels into a 16-bit cyclic signature and then hands the result out four bits at a time. The register is a chain of four 4-bit stages. In serial mode every gated clock moves one data bit into the first stage, and the bits shift toward the most significant bit. The serial input is the probe bit XORed with four feedback taps. The probe level comes from a pair of qualifiers: one marks a one and the other marks a zero. If neither qualifier is active, or both are, the level is treated as unusable, and the most recently stored valid level is fed in instead.

In parallel mode each shift strobe moves every stage forward by one whole nibble. A 4-bit event nibble enters the first stage, and the last stage leaves toward the transmit side. Four strobes therefore expose the whole signature, highest nibble first. After those four strobes the register holds the event nibbles, which then leave by the same path. A read-next strobe gates the last stage onto a 4-bit output bus. When the strobe is low, the bus reads zero. A synchronous clear empties every register in the block.

Top module: `sig_nibble_reg`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, the signature is all zero and the bus reads 0 during a read.
- R2: A serial step (`gclk_en_i`=1, `par_shift_i`=0) updates the signature as sig <= {sig[14:0], fb}. Here fb = d ^ sig[6] ^ sig[8] ^ sig[11] ^ sig[15], with bit 0 as the first bit in and bit 15 as the oldest bit. This gives the polynomial x^16+x^12+x^9+x^7+1.
- R3: During a serial step, `vhi_i`=1 with `vlo_i`=0 gives d=1, and `vlo_i`=1 with `vhi_i`=0 gives d=0. A valid level is stored as the last valid level.
- R4: During a serial step, if `vhi_i` and `vlo_i` are both 0 or both 1, d equals the stored last valid level. After reset or clear that stored level is 0, and an invalid step does not change it.
- R5: When `gclk_en_i`, `par_shift_i` and `clr_i` are all low, the signature and the stored level hold.
- R6: A parallel step (`par_shift_i`=1) updates the signature as sig <= {sig[11:0], evt_i}. The nibble sig[15:12] (last stage) is the one that leaves.
- R7: When `par_shift_i` and `gclk_en_i` are both high, only the parallel step happens, and the stored level is not updated.
- R8: `bus_o` equals sig[15:12] while `rd_next_i`=1 and equals 0 while `rd_next_i`=0. It reflects the register contents before the coming edge.
- R9: `clr_i`=1 at a clock edge clears the signature and the stored level, and it overrides both shift modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all state |
| gclk_en_i | input | 1 | Gated-clock enable: one serial step |
| vhi_i | input | 1 | Probe level valid high |
| vlo_i | input | 1 | Probe level valid low |
| par_shift_i | input | 1 | Nibble shift strobe |
| evt_i | input | 4 | Event nibble loaded into the first stage |
| rd_next_i | input | 1 | Read-next strobe, gates the last stage to the bus |
| bus_o | output | 4 | Readout bus, zero when not reading |

## Verification
The serial path is tested with three kinds of input. A run of constant ones fills the register through the taps. A pseudo-random bit stream tests every tap position, because a single missing or misplaced tap changes the nibbles that come out. Streams with frequent invalid levels, both "neither" and "both", separate substitution with the last valid level from a fixed default. The readout tests the order of nibbles, the arrival of event nibbles after four shifts, mixed strobes where the parallel step must win, and a clear between runs that must also reset the stored level.

// File: rtl/sig_pkg.sv
package sig_pkg;
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned NUM_STG  = 4;
  localparam int unsigned SIG_W    = NIB_W * NUM_STG;
  localparam int unsigned TAP_MASK = 32'h0000_8940;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_SER  = 2'd1,
    OP_PAR  = 2'd2
  } stg_op_e;
endpackage

// File: rtl/sig_level_sel.sv
module sig_level_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic take_i,
  input  logic vhi_i,
  input  logic vlo_i,
  output logic bit_o
);
  logic last_q;
  logic lvl_ok;

  assign lvl_ok = vhi_i ^ vlo_i;
  assign bit_o  = lvl_ok ? vhi_i : last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 last_q <= 1'b0;
    else if (clr_i)              last_q <= 1'b0;
    else if (take_i && lvl_ok)   last_q <= vhi_i;
  end
endmodule

// File: rtl/sig_stage.sv
module sig_stage
  import sig_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  stg_op_e      op_i,
  input  logic         ser_i,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else if (clr_i) q_q <= '0;
    else begin
      case (op_i)
        OP_SER:  q_q <= {q_q[W-2:0], ser_i};
        OP_PAR:  q_q <= par_i;
        default: q_q <= q_q;
      endcase
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/sig_tx_gate.sv
module sig_tx_gate #(
  parameter int unsigned W = 4
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  assign q_o = en_i ? d_i : '0;
endmodule

// File: rtl/sig_nibble_reg.sv
module sig_nibble_reg
  import sig_pkg::*;
#(
  parameter int unsigned NIB_WIDTH  = sig_pkg::NIB_W,
  parameter int unsigned NUM_STAGES = sig_pkg::NUM_STG,
  parameter int unsigned TAPS       = sig_pkg::TAP_MASK
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 gclk_en_i,
  input  logic                 vhi_i,
  input  logic                 vlo_i,
  input  logic                 par_shift_i,
  input  logic [NIB_WIDTH-1:0] evt_i,
  input  logic                 rd_next_i,
  output logic [NIB_WIDTH-1:0] bus_o
);
  localparam int unsigned SW = NIB_WIDTH * NUM_STAGES;
  localparam logic [SW-1:0] TAP_V = SW'(TAPS);

  stg_op_e              op;
  logic                 data_bit;
  logic                 fb;
  logic [SW-1:0]        sig_q;
  logic [NIB_WIDTH-1:0] stg_q   [NUM_STAGES];
  logic [NIB_WIDTH-1:0] stg_par [NUM_STAGES];
  logic                 stg_ser [NUM_STAGES];

  // parallel strobe wins over serial
  always_comb begin
    if (par_shift_i)    op = OP_PAR;
    else if (gclk_en_i) op = OP_SER;
    else                op = OP_HOLD;
  end

  sig_level_sel u_lvl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .take_i (op == OP_SER),
    .vhi_i  (vhi_i),
    .vlo_i  (vlo_i),
    .bit_o  (data_bit)
  );

  assign fb = data_bit ^ (^(sig_q & TAP_V));

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stg
    if (k == 0) begin : g_head
      assign stg_ser[k] = fb;
      assign stg_par[k] = evt_i;
    end else begin : g_tail
      assign stg_ser[k] = stg_q[k-1][NIB_WIDTH-1];
      assign stg_par[k] = stg_q[k-1];
    end

    sig_stage #(.W(NIB_WIDTH)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .op_i   (op),
      .ser_i  (stg_ser[k]),
      .par_i  (stg_par[k]),
      .q_o    (stg_q[k])
    );

    assign sig_q[k*NIB_WIDTH +: NIB_WIDTH] = stg_q[k];
  end

  sig_tx_gate #(.W(NIB_WIDTH)) u_tx (
    .en_i (rd_next_i),
    .d_i  (stg_q[NUM_STAGES-1]),
    .q_o  (bus_o)
  );
endmodule

// File: rtl/sig_nibble_reg_chk.sv
module sig_nibble_reg_chk #(
  parameter int unsigned NW = 4,
  parameter int unsigned SW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          gclk_en_i,
  input logic          par_shift_i,
  input logic [NW-1:0] evt_i,
  input logic          rd_next_i,
  input logic [NW-1:0] bus_o,
  input logic [SW-1:0] sig_q
);
  // R9
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sig_q == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !gclk_en_i && !par_shift_i) |=> $stable(sig_q));

  // R6
  evt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && par_shift_i) |=> (sig_q[NW-1:0] == $past(evt_i)));

  // R6
  nib_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && par_shift_i) |=> (sig_q[SW-1:NW] == $past(sig_q[SW-NW-1:0])));

  // R2
  ser_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && gclk_en_i && !par_shift_i) |=> (sig_q[SW-1:1] == $past(sig_q[SW-2:0])));

  // R8
  bus_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_next_i |-> (bus_o == '0));

  // R8
  bus_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_next_i |-> (bus_o == sig_q[SW-1:SW-NW]));
endmodule

bind sig_nibble_reg sig_nibble_reg_chk #(.NW(NIB_WIDTH), .SW(SW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (clr_i),
  .gclk_en_i   (gclk_en_i),
  .par_shift_i (par_shift_i),
  .evt_i       (evt_i),
  .rd_next_i   (rd_next_i),
  .bus_o       (bus_o),
  .sig_q       (sig_q)
);

// File: tb/sig_nibble_reg_bench.sv
`timescale 1ns/1ps
module sig_nibble_reg_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic       gclk_en_i = 1'b0;
  logic       vhi_i = 1'b0;
  logic       vlo_i = 1'b0;
  logic       par_shift_i = 1'b0;
  logic [3:0] evt_i = '0;
  logic       rd_next_i = 1'b0;
  logic [3:0] bus_o;

  always #2 clk_i = ~clk_i;

  sig_nibble_reg u_sig_nibble_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .gclk_en_i(gclk_en_i),
    .vhi_i(vhi_i), .vlo_i(vlo_i), .par_shift_i(par_shift_i), .evt_i(evt_i),
    .rd_next_i(rd_next_i), .bus_o(bus_o)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [15:0] m_sig = '0;
  logic        m_last = 1'b0;
  logic [3:0]  evt_ctr = 4'h3;
  logic [31:0] lfsr = 32'h1ace_b00c;

  function automatic void note(bit ok, string tag, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: bus_o=%h expected=%h", tag, act, exp);
    end
  endfunction

  // monitor: scoreboard pops on reads, idle bus must be zero
  always @(negedge clk_i) begin
    #1;
    if (rst_ni) begin
      if (rd_next_i) begin
        if (exp_q.size() == 0) note(1'b0, "R8 (no expected item)", bus_o, 4'h0);
        else begin
          logic [3:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          note(bus_o === e, t, bus_o, e);
        end
      end else if (par_shift_i || gclk_en_i) begin
        note(bus_o === 4'h0, "R8 idle bus", bus_o, 4'h0);
      end
    end
  end

  // driver: one cycle of stimulus plus model update
  task automatic step(input bit clr, input bit g, input bit hi, input bit lo,
                      input bit par, input logic [3:0] ev, input bit rd, input string tag);
    @(negedge clk_i);
    clr_i = clr; gclk_en_i = g; vhi_i = hi; vlo_i = lo;
    par_shift_i = par; evt_i = ev; rd_next_i = rd;
    if (rd) begin
      exp_q.push_back(m_sig[15:12]);
      tag_q.push_back(tag);
    end
    if (clr) begin
      m_sig = '0; m_last = 1'b0;
    end else if (par) begin
      m_sig = {m_sig[11:0], ev};
    end else if (g) begin
      logic d;
      if (hi ^ lo) begin d = hi; m_last = hi; end
      else d = m_last;
      m_sig = {m_sig[14:0], d ^ m_sig[6] ^ m_sig[8] ^ m_sig[11] ^ m_sig[15]};
    end
  endtask

  task automatic dump(input string tag);
    for (int i = 0; i < 4; i++) begin
      evt_ctr = evt_ctr + 4'h5;
      step(0, 0, 0, 0, 1, evt_ctr, 1, tag);
    end
  endtask

  task automatic ser_run(input int n, input int inval_pct, input string tag);
    for (int i = 0; i < n; i++) begin
      bit hi, lo;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      hi = lfsr[0];
      lo = ~lfsr[0];
      if ((lfsr[15:8] % 100) < inval_pct) begin
        hi = lfsr[3]; lo = lfsr[3];
      end
      step(0, 1, hi, lo, 0, 4'h0, 0, tag);
    end
  endtask

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state reads zero
    dump("R1 reset state");
    // R3: constant ones, then readout
    for (int i = 0; i < 20; i++) step(0, 1, 1, 0, 0, 4'h0, 0, "R3");
    dump("R3 ones stream");
    // R6: event nibbles follow the signature out
    dump("R6 event nibbles");
    step(1, 0, 0, 0, 0, 4'h0, 0, "R9");
    // R2: random valid stream exercises every tap
    for (int k = 0; k < 6; k++) begin
      ser_run(37 + k, 0, "R2");
      dump("R2 random stream");
      step(1, 0, 0, 0, 0, 4'h0, 0, "R9");
    end
    // R4: invalid levels substitute the stored level
    for (int k = 0; k < 6; k++) begin
      ser_run(45, 40, "R4");
      dump("R4 invalid substitution");
    end
    // R5: idle cycles hold state
    ser_run(25, 10, "R5");
    for (int i = 0; i < 7; i++) step(0, 0, 1, 0, 0, 4'hf, 0, "R5");
    dump("R5 hold");
    // R7: parallel wins over serial, stored level untouched
    step(1, 0, 0, 0, 0, 4'h0, 0, "R9");
    step(0, 1, 1, 0, 0, 4'h0, 0, "R7");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 1, 1, 4'(i + 9), 1, "R7 par over ser");
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 0, 4'h0, 0, "R7");
    dump("R7 stored level kept");
    // R9: clear mid-run resets signature and stored level
    ser_run(30, 0, "R9");
    step(0, 1, 1, 0, 0, 4'h0, 0, "R9");
    step(1, 1, 1, 0, 1, 4'h7, 0, "R9 clear wins");
    for (int i = 0; i < 9; i++) step(0, 1, 1, 1, 0, 4'h0, 0, "R9");
    dump("R9 clear incl stored level");
    step(1, 0, 0, 0, 0, 4'h0, 0, "R9");
    dump("R9 cleared");
    // R8: read without shift leaves state alone
    ser_run(20, 0, "R8");
    step(0, 0, 0, 0, 0, 4'h0, 1, "R8 read only");
    step(0, 0, 0, 0, 0, 4'h0, 1, "R8 read again");
    dump("R8 after plain reads");
    step(0, 0, 0, 0, 0, 4'h0, 0, "R8");
    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R8: %0d reads never observed", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule